// File: doc/BRIEF.md
# Block Address Translation Matcher

This block maps a 32-bit effective address to a physical address through a small set of programmable block-mapping entries. Instruction fetches and data accesses each have their own bank of eight entries. Every entry holds an effective base, a match mask, a physical base, a user-mode enable, a supervisor-mode enable and a 2-bit protection code. A requester presents the address, the access side, the privilege level and a write flag with a one-cycle strobe. On the next clock edge the block returns a hit flag, the physical address and read, write and execute permissions.

The scan runs in priority order. An entry whose address matches but whose protection refuses the access does not raise a fault. It is passed over, so a later entry may still accept the access. When no entry accepts, the block reports a miss. Software loads entries through a plain register write port that addresses one field of one entry per cycle.

Top module: `blk_xlate`

## Requirements
- R1: `req_data`=1 selects the data bank and `req_data`=0 selects the instruction bank. An entry in the other bank never affects the result.
- R2: With `req_user`=1 an entry takes part only if its user enable is set. With `req_user`=0 only its supervisor enable is consulted.
- R3: An entry's address matches when (`req_ea` AND mask) equals its effective base.
- R4: On a hit, `rsp_pa` is the physical base ORed with the bits of `req_ea` that are zero in the mask.
- R5: Protection code 0 allows nothing, code 1 allows read only, and codes 2 and 3 allow read and write. On a hit `rsp_rd` and `rsp_ex` are 1, and `rsp_wr` is 1 only for codes 2 and 3.
- R6: An entry that matches but allows no read, or that allows no write on an access with `req_write`=1, is skipped. The scan continues with the next entry.
- R7: When several entries accept the access, the lowest-numbered one supplies the result.
- R8: When no entry accepts, `rsp_hit`, `rsp_rd`, `rsp_wr` and `rsp_ex` are 0 and `rsp_pa` is 0.
- R9: The result is captured on the rising edge where `req_valid`=1. `rsp_valid` is 1 for exactly the cycle after each strobe. The outputs hold their values while `req_valid`=0.
- R10: Reset clears every field of every entry, including both mode enables. Before programming, no lookup hits, even though a zero mask matches any address.
- R11: A write with `cfg_we`=1 loads `cfg_wdata` into the entry numbered `cfg_idx` of bank `cfg_bank` (0 instruction, 1 data). The field is chosen by `cfg_sel`: 0 effective base, 1 mask, 2 physical base, 3 control. The control word uses bit 3 for the user enable, bit 2 for the supervisor enable and bits 1:0 for protection. The write is seen by lookups strobed after the edge that stores it, and not by a lookup strobed in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Entry field write enable |
| cfg_bank | input | 1 | Bank to write: 0 instruction, 1 data |
| cfg_idx | input | 3 | Entry number to write |
| cfg_sel | input | 2 | Field to write |
| cfg_wdata | input | 32 | Field value |
| req_valid | input | 1 | Lookup strobe |
| req_ea | input | 32 | Effective address |
| req_data | input | 1 | Access side: 1 data, 0 instruction |
| req_user | input | 1 | 1 for user mode, 0 for supervisor |
| req_write | input | 1 | Access is a store |
| rsp_valid | output | 1 | Result captured last edge |
| rsp_hit | output | 1 | An entry accepted the access |
| rsp_pa | output | 32 | Physical address |
| rsp_rd | output | 1 | Read permitted |
| rsp_wr | output | 1 | Write permitted |
| rsp_ex | output | 1 | Execute permitted |

## Verification
Each lookup result is due one clock edge after its strobe. The bench drives inputs on the falling edge and samples one time unit after the following rising edge. A field write becomes visible one edge after it is driven, so a lookup strobed in the same cycle must still see the old entry. The bench checks this by combining a control write and a lookup in one cycle. Hold behaviour is checked by changing the request inputs with the strobe low and sampling again after a rising edge.

// File: rtl/blk_xlate_pkg.sv
package blk_xlate_pkg;
  localparam int ADDR_W = 32;
  localparam int PROT_W = 2;

  typedef enum logic [1:0] {
    FLD_EBASE = 2'd0,
    FLD_MASK  = 2'd1,
    FLD_PBASE = 2'd2,
    FLD_CTRL  = 2'd3
  } fld_e;

  typedef struct packed {
    logic [ADDR_W-1:0] ebase;
    logic [ADDR_W-1:0] mask;
    logic [ADDR_W-1:0] pbase;
    logic              u_en;
    logic              s_en;
    logic [PROT_W-1:0] prot;
  } xent_t;
endpackage

// File: rtl/blk_xlate_bank.sv
module blk_xlate_bank
  import blk_xlate_pkg::*;
#(
  parameter int NUM_ENT = 8,
  localparam int IDX_W = $clog2(NUM_ENT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [1:0]        sel,
  input  logic [ADDR_W-1:0] wdata,
  output xent_t             ents [NUM_ENT]
);
  for (genvar e = 0; e < NUM_ENT; e++) begin : g_ent
    xent_t ent_q, ent_d;
    logic  ent_en;

    assign ent_en = we && (idx == IDX_W'(e));

    always_comb begin
      ent_d = ent_q;
      unique case (fld_e'(sel))
        FLD_EBASE: ent_d.ebase = wdata;
        FLD_MASK:  ent_d.mask  = wdata;
        FLD_PBASE: ent_d.pbase = wdata;
        FLD_CTRL: begin
          ent_d.u_en = wdata[3];
          ent_d.s_en = wdata[2];
          ent_d.prot = wdata[PROT_W-1:0];
        end
        default: ent_d = ent_q;
      endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ent_q <= '0;
      else if (ent_en) ent_q <= ent_d;
    end

    assign ents[e] = ent_q;
  end
endmodule

// File: rtl/blk_xlate_match.sv
module blk_xlate_match
  import blk_xlate_pkg::*;
#(
  parameter int NUM_ENT = 8
) (
  input  xent_t             ents [NUM_ENT],
  input  logic [ADDR_W-1:0] ea,
  input  logic              user,
  input  logic              write,
  output logic [NUM_ENT-1:0] grant,
  output logic              hit,
  output logic [ADDR_W-1:0] pa,
  output logic              rd,
  output logic              wr
);
  logic [NUM_ENT-1:0] accept;

  for (genvar e = 0; e < NUM_ENT; e++) begin : g_chk
    logic mode_ok, addr_ok, rd_ok, wr_ok;
    assign mode_ok = user ? ents[e].u_en : ents[e].s_en;
    assign addr_ok = (ea & ents[e].mask) == ents[e].ebase;
    assign rd_ok   = ents[e].prot != '0;
    assign wr_ok   = ents[e].prot[PROT_W-1];
    assign accept[e] = mode_ok && addr_ok && rd_ok && (!write || wr_ok);
  end

  always_comb begin
    grant = '0;
    hit   = 1'b0;
    pa    = '0;
    rd    = 1'b0;
    wr    = 1'b0;
    for (int e = 0; e < NUM_ENT; e++) begin
      if (accept[e] && !hit) begin
        hit      = 1'b1;
        grant[e] = 1'b1;
        pa       = ents[e].pbase | (ea & ~ents[e].mask);
        rd       = 1'b1;
        wr       = ents[e].prot[PROT_W-1];
      end
    end
  end
endmodule

// File: rtl/blk_xlate.sv
module blk_xlate
  import blk_xlate_pkg::*;
#(
  parameter int NUM_ENT = 8,
  localparam int IDX_W = $clog2(NUM_ENT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_bank,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [1:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_ea,
  input  logic              req_data,
  input  logic              req_user,
  input  logic              req_write,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [ADDR_W-1:0] rsp_pa,
  output logic              rsp_rd,
  output logic              rsp_wr,
  output logic              rsp_ex
);
  localparam int NUM_BANK = 2;

  logic [1:0] rst_pipe;
  logic       rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sn = rst_pipe[1];

  xent_t bank_ents [NUM_BANK][NUM_ENT];

  for (genvar b = 0; b < NUM_BANK; b++) begin : g_bank
    blk_xlate_bank #(.NUM_ENT(NUM_ENT)) u_bank (
      .clk   (clk),
      .rst_n (rst_sn),
      .we    (cfg_we && (cfg_bank == 1'(b))),
      .idx   (cfg_idx),
      .sel   (cfg_sel),
      .wdata (cfg_wdata),
      .ents  (bank_ents[b])
    );
  end

  xent_t sel_ents [NUM_ENT];
  always_comb begin
    for (int e = 0; e < NUM_ENT; e++)
      sel_ents[e] = bank_ents[req_data ? 1 : 0][e];
  end

  logic [NUM_ENT-1:0] grant;
  logic               m_hit, m_rd, m_wr;
  logic [ADDR_W-1:0]  m_pa;

  blk_xlate_match #(.NUM_ENT(NUM_ENT)) u_match (
    .ents  (sel_ents),
    .ea    (req_ea),
    .user  (req_user),
    .write (req_write),
    .grant (grant),
    .hit   (m_hit),
    .pa    (m_pa),
    .rd    (m_rd),
    .wr    (m_wr)
  );

  logic              hit_d, rd_d, wr_d, ex_d;
  logic [ADDR_W-1:0] pa_d;

  always_comb begin
    hit_d = m_hit;
    pa_d  = m_pa;
    rd_d  = m_rd;
    wr_d  = m_wr;
    ex_d  = m_hit;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_pa    <= '0;
      rsp_rd    <= 1'b0;
      rsp_wr    <= 1'b0;
      rsp_ex    <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_hit <= hit_d;
        rsp_pa  <= pa_d;
        rsp_rd  <= rd_d;
        rsp_wr  <= wr_d;
        rsp_ex  <= ex_d;
      end
    end
  end

  assert_one_winner_R7: assert property (@(posedge clk) disable iff (!rst_sn)
    $onehot0(grant) && (m_hit == (grant != '0)));

  assert_hit_perms_R5: assert property (@(posedge clk) disable iff (!rst_sn)
    rsp_hit |-> (rsp_rd && rsp_ex));

  assert_miss_quiet_R8: assert property (@(posedge clk) disable iff (!rst_sn)
    !rsp_hit |-> (!rsp_rd && !rsp_wr && !rsp_ex && rsp_pa == '0));

  assert_write_granted_R6: assert property (@(posedge clk) disable iff (!rst_sn)
    (req_valid && req_write) |=> (!rsp_hit || rsp_wr));

  assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_sn)
    !req_valid |=> ($stable(rsp_hit) && $stable(rsp_pa) && $stable(rsp_wr) && !rsp_valid));
endmodule

// File: tb/blk_xlate_tb.sv
module blk_xlate_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we, cfg_bank;
  logic [2:0]  cfg_idx;
  logic [1:0]  cfg_sel;
  logic [31:0] cfg_wdata;
  logic        req_valid, req_data, req_user, req_write;
  logic [31:0] req_ea;
  logic        rsp_valid, rsp_hit, rsp_rd, rsp_wr, rsp_ex;
  logic [31:0] rsp_pa;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  blk_xlate u_dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_bank(cfg_bank), .cfg_idx(cfg_idx),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_ea(req_ea), .req_data(req_data),
    .req_user(req_user), .req_write(req_write),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_pa(rsp_pa),
    .rsp_rd(rsp_rd), .rsp_wr(rsp_wr), .rsp_ex(rsp_ex)
  );

  typedef struct packed {
    logic [31:0] ea;
    logic        dside;
    logic        user;
    logic        write;
    logic        hit;
    logic [31:0] pa;
    logic        rd;
    logic        wr;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{32'h0123_4567, 1'b0, 1'b0, 1'b0, 1'b1, 32'h8123_4567, 1'b1, 1'b1}, // R1 R3 R4
    '{32'h0123_4567, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0,         1'b0, 1'b0}, // R2
    '{32'h0123_4567, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0,         1'b0, 1'b0}, // R1
    '{32'h1005_0ABC, 1'b1, 1'b0, 1'b0, 1'b1, 32'h2005_0ABC, 1'b1, 1'b0}, // R7 R5
    '{32'h1005_0ABC, 1'b1, 1'b0, 1'b1, 1'b1, 32'h3005_0ABC, 1'b1, 1'b1}, // R6
    '{32'h10A0_0004, 1'b1, 1'b1, 1'b0, 1'b1, 32'h30A0_0004, 1'b1, 1'b1}, // R3
    '{32'h4023_0000, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0,         1'b0, 1'b0}, // R6 R2
    '{32'h4023_0000, 1'b1, 1'b1, 1'b0, 1'b1, 32'h6023_0000, 1'b1, 1'b1}, // R2
    '{32'h7FFF_FFFC, 1'b1, 1'b1, 1'b1, 1'b1, 32'h9FFF_FFFC, 1'b1, 1'b1}, // R4
    '{32'h7FFF_FFFC, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0,         1'b0, 1'b0}, // R2
    '{32'hF000_0000, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0,         1'b0, 1'b0}, // R8
    '{32'h1000_0000, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0,         1'b0, 1'b0}, // R1
    '{32'h1000_0000, 1'b1, 1'b1, 1'b1, 1'b1, 32'h3000_0000, 1'b1, 1'b1}  // R6
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_field(input logic bank, input logic [2:0] idx,
                          input logic [1:0] sel, input logic [31:0] val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_bank = bank; cfg_idx = idx; cfg_sel = sel; cfg_wdata = val;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic prog(input logic bank, input logic [2:0] idx, input logic [31:0] eb,
                      input logic [31:0] mk, input logic [31:0] pb, input logic [3:0] ctl);
    wr_field(bank, idx, 2'd0, eb);
    wr_field(bank, idx, 2'd1, mk);
    wr_field(bank, idx, 2'd2, pb);
    wr_field(bank, idx, 2'd3, {28'h0, ctl});
  endtask

  task automatic lookup(input logic [31:0] ea, input logic dside,
                        input logic user, input logic write);
    @(negedge clk);
    req_valid = 1'b1; req_ea = ea; req_data = dside; req_user = user; req_write = write;
    @(posedge clk);
    #1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    #200000;
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cfg_we = 0; cfg_bank = 0; cfg_idx = 0; cfg_sel = 0; cfg_wdata = 0;
    req_valid = 0; req_ea = 0; req_data = 0; req_user = 0; req_write = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    // R10 / R9: reset state
    chk("R10 rsp_hit after reset", 32'(rsp_hit), 32'h0);
    chk("R9 rsp_valid after reset", 32'(rsp_valid), 32'h0);

    // R10: zero entries (mask 0) must not match before programming
    @(negedge clk);
    req_valid = 1; req_ea = 32'h1234_5678; req_data = 1; req_user = 0; req_write = 0;
    @(posedge clk); #1;
    chk("R10 no hit unprogrammed", 32'(rsp_hit), 32'h0);
    chk("R9 rsp_valid pulse", 32'(rsp_valid), 32'h1);
    @(negedge clk) req_valid = 0;
    @(posedge clk); #1;
    chk("R9 rsp_valid drops", 32'(rsp_valid), 32'h0);

    // R11: program entries; control bit3 user, bit2 supervisor, [1:0] prot
    prog(1'b0, 3'd0, 32'h0000_0000, 32'hF000_0000, 32'h8000_0000, 4'b0110);
    prog(1'b1, 3'd0, 32'h1000_0000, 32'hFFF0_0000, 32'h2000_0000, 4'b1101);
    prog(1'b1, 3'd1, 32'h1000_0000, 32'hFF00_0000, 32'h3000_0000, 4'b1111);
    prog(1'b1, 3'd2, 32'h4000_0000, 32'hF000_0000, 32'h5000_0000, 4'b0100);
    prog(1'b1, 3'd3, 32'h4000_0000, 32'hFF00_0000, 32'h6000_0000, 4'b1010);
    prog(1'b1, 3'd5, 32'h7000_0000, 32'hF000_0000, 32'h9000_0000, 4'b1010);

    for (int v = 0; v < NV; v++) begin
      lookup(VECS[v].ea, VECS[v].dside, VECS[v].user, VECS[v].write);
      chk($sformatf("R3 R4 R5 R6 R7 vec%0d hit", v), 32'(rsp_hit), 32'(VECS[v].hit));
      chk($sformatf("R4 vec%0d pa", v), rsp_pa, VECS[v].pa);
      chk($sformatf("R5 vec%0d rd", v), 32'(rsp_rd), 32'(VECS[v].rd));
      chk($sformatf("R5 vec%0d wr", v), 32'(rsp_wr), 32'(VECS[v].wr));
      chk($sformatf("R5 vec%0d ex", v), 32'(rsp_ex), 32'(VECS[v].hit));
    end

    // R9: outputs hold while strobe low even as inputs change
    lookup(32'h7000_0010, 1'b1, 1'b1, 1'b0);
    @(negedge clk);
    req_ea = 32'hF000_0000; req_user = 0;
    @(posedge clk); #1;
    chk("R9 hold hit", 32'(rsp_hit), 32'h1);
    chk("R9 hold pa", rsp_pa, 32'h9000_0010);

    // R11: control write and lookup in same cycle sees old entry
    wr_field(1'b1, 3'd7, 2'd0, 32'hF000_0000);
    wr_field(1'b1, 3'd7, 2'd1, 32'hF000_0000);
    wr_field(1'b1, 3'd7, 2'd2, 32'h0A00_0000);
    @(negedge clk);
    cfg_we = 1; cfg_bank = 1; cfg_idx = 3'd7; cfg_sel = 2'd3; cfg_wdata = 32'h7;
    req_valid = 1; req_ea = 32'hF000_0123; req_data = 1; req_user = 0; req_write = 1;
    @(posedge clk); #1;
    chk("R11 same-cycle write unseen", 32'(rsp_hit), 32'h0);
    @(negedge clk);
    cfg_we = 0;
    @(posedge clk); #1;
    chk("R11 write seen next lookup", 32'(rsp_hit), 32'h1);
    chk("R11 pa from new entry", rsp_pa, 32'h0A00_0123);
    @(negedge clk) req_valid = 0;

    // R1: instruction bank unaffected by data entry 7
    lookup(32'hF000_0123, 1'b0, 1'b0, 1'b0);
    chk("R1 instr bank miss", 32'(rsp_hit), 32'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule